// File: doc/BRIEF.md
# Single-Position Shift and Rotate Unit

This unit moves an operand by exactly one bit position, or inverts it, and produces the condition flags that follow from the result. The operand may be a byte, a word (two bytes) or a long (four bytes). The size selects which bit counts as the most significant one, and so where bits leave and enter. Nine operations are offered: logical left and right shifts, arithmetic left and right shifts, plain rotates in both directions, rotates that pass through the carry flag in both directions, and a bitwise complement.

The unit sits beside an ALU in a processor datapath. The surrounding pipeline supplies the operand, the current carry flag, an operation code and a size code. One clock later the unit returns the result, zero-extended above the selected width, with new negative, zero, overflow and carry flags. The unit has a single register stage and accepts a new operation on every cycle.

Top module: `shrot_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first operation is loaded, `result_o` is 0 and all four flags are 0.
- R2: The outputs at a clock edge reflect the inputs sampled at the previous edge. Changing the inputs between edges does not alter the outputs until the next edge.
- R3: `size_i` encodes 0 = byte (8 bits), 1 = word (16 bits), 2 = long (32 bits), and 3 = long. Input bits above the selected width are ignored, and result bits above it are 0.
- R4: Op 0 (logical left) and op 2 (arithmetic left) shift left by one and insert 0 at bit 0. C takes the old top bit.
- R5: Op 1 (logical right) shifts right by one and inserts 0 at the top bit. C takes the old bit 0.
- R6: Op 3 (arithmetic right) shifts right by one and keeps the old top bit in the top position. C takes the old bit 0.
- R7: Op 4 (rotate left) moves the old top bit into both bit 0 and C.
- R8: Op 5 (rotate right) moves the old bit 0 into both the top bit and C.
- R9: Op 6 (rotate left through carry) shifts left, puts the incoming carry into bit 0, and loads C with the old top bit.
- R10: Op 7 (rotate right through carry) shifts right, puts the incoming carry into the top bit, and loads C with the old bit 0.
- R11: Op 8 (complement) inverts every bit within the selected width. C equals the incoming carry.
- R12: N is the top bit of the result at the selected width, and Z is 1 exactly when the result within that width is 0. V is 0 for every operation.
- R13: Op codes 9 to 15 return the operand masked to the selected width, and C equals the incoming carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low reset of the output register |
| operand_i | input | 32 | Operand; only the low bits of the selected width are used |
| carry_i | input | 1 | Incoming carry flag |
| op_i | input | 4 | Operation code |
| size_i | input | 2 | Operand size code |
| result_o | output | 32 | Result, zero above the selected width |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag, always 0 |
| c_o | output | 1 | Carry flag |

## Verification
The assertions compare each registered output with the inputs of the previous edge. They therefore assume that every edge after reset loads a real operation, and this holds because the unit has no enable. Because the top-bit position used by the assertions comes from the previous `size_i`, the bench drives all four size codes. That includes code 3, which must behave like a long. The bench also fills the bits above the active width with random data, so a leak from those bits into the result, or into the N and Z flags, would show at once. The carry input is swept through both values for every operation, because the through-carry rotates, the complement and the unused codes all pass it on.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
   localparam int OP_W   = 4;
   localparam int SIZE_W = 2;
   localparam int NUM_SIZES = 3;

   localparam logic [OP_W-1:0] OP_SHL_LOG = 4'd0;
   localparam logic [OP_W-1:0] OP_SHR_LOG = 4'd1;
   localparam logic [OP_W-1:0] OP_SHL_ARI = 4'd2;
   localparam logic [OP_W-1:0] OP_SHR_ARI = 4'd3;
   localparam logic [OP_W-1:0] OP_ROL     = 4'd4;
   localparam logic [OP_W-1:0] OP_ROR     = 4'd5;
   localparam logic [OP_W-1:0] OP_ROLC    = 4'd6;
   localparam logic [OP_W-1:0] OP_RORC    = 4'd7;
   localparam logic [OP_W-1:0] OP_INV     = 4'd8;

   localparam logic [SIZE_W-1:0] SZ_BYTE = 2'd0;
   localparam logic [SIZE_W-1:0] SZ_WORD = 2'd1;
   localparam logic [SIZE_W-1:0] SZ_LONG = 2'd2;

   // Map a size code onto a lane index; code 3 folds onto the long lane.
   function automatic logic [1:0] lane_of(input logic [SIZE_W-1:0] sz);
      return (sz == SZ_BYTE) ? 2'd0 : (sz == SZ_WORD) ? 2'd1 : 2'd2;
   endfunction
endpackage

// File: rtl/shrot_lane.sv
module shrot_lane #(
   parameter int W      = 8,
   parameter int DATA_W = 32
) (
   input  logic [W-1:0]              operand_i,
   input  logic                      carry_i,
   input  logic [shrot_pkg::OP_W-1:0] op_i,
   output logic [DATA_W-1:0]         result_o,
   output logic                      n_o,
   output logic                      z_o,
   output logic                      c_o
);
   import shrot_pkg::*;

   localparam int MSB = W - 1;

   logic [W-1:0] r;

   always_comb begin
      r   = operand_i;
      c_o = carry_i;
      case (op_i)
         OP_SHL_LOG, OP_SHL_ARI: begin
            r   = {operand_i[MSB-1:0], 1'b0};
            c_o = operand_i[MSB];
         end
         OP_SHR_LOG: begin
            r   = {1'b0, operand_i[MSB:1]};
            c_o = operand_i[0];
         end
         OP_SHR_ARI: begin
            r   = {operand_i[MSB], operand_i[MSB:1]};
            c_o = operand_i[0];
         end
         OP_ROL: begin
            r   = {operand_i[MSB-1:0], operand_i[MSB]};
            c_o = operand_i[MSB];
         end
         OP_ROR: begin
            r   = {operand_i[0], operand_i[MSB:1]};
            c_o = operand_i[0];
         end
         OP_ROLC: begin
            r   = {operand_i[MSB-1:0], carry_i};
            c_o = operand_i[MSB];
         end
         OP_RORC: begin
            r   = {carry_i, operand_i[MSB:1]};
            c_o = operand_i[0];
         end
         OP_INV: begin
            r   = ~operand_i;
            c_o = carry_i;
         end
         default: begin
            r   = operand_i;
            c_o = carry_i;
         end
      endcase
   end

   always_comb begin
      result_o        = '0;
      result_o[MSB:0] = r;
   end

   assign n_o = r[MSB];
   assign z_o = ~|r;
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit #(
   parameter int BYTE_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [4*BYTE_W-1:0]         operand_i,
   input  logic                        carry_i,
   input  logic [shrot_pkg::OP_W-1:0]   op_i,
   input  logic [shrot_pkg::SIZE_W-1:0] size_i,
   output logic [4*BYTE_W-1:0]         result_o,
   output logic                        n_o,
   output logic                        z_o,
   output logic                        v_o,
   output logic                        c_o
);
   import shrot_pkg::*;

   localparam int DATA_W = 4 * BYTE_W;

   if (BYTE_W < 2) begin : g_bad_width
      $error("shrot_unit: BYTE_W must be at least 2");
   end

   logic [DATA_W-1:0] lane_res [NUM_SIZES];
   logic              lane_n   [NUM_SIZES];
   logic              lane_z   [NUM_SIZES];
   logic              lane_c   [NUM_SIZES];

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
      localparam int LW = BYTE_W << g;
      shrot_lane #(.W(LW), .DATA_W(DATA_W)) lane_i (
         .operand_i (operand_i[LW-1:0]),
         .carry_i   (carry_i),
         .op_i      (op_i),
         .result_o  (lane_res[g]),
         .n_o       (lane_n[g]),
         .z_o       (lane_z[g]),
         .c_o       (lane_c[g])
      );
   end

   logic [1:0] sel;
   assign sel = lane_of(size_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_o <= '0;
         n_o      <= 1'b0;
         z_o      <= 1'b0;
         v_o      <= 1'b0;
         c_o      <= 1'b0;
      end else begin
         result_o <= lane_res[sel];
         n_o      <= lane_n[sel];
         z_o      <= lane_z[sel];
         v_o      <= 1'b0;
         c_o      <= lane_c[sel];
      end
   end

   // ---------------- assertions ----------------
   function automatic logic [DATA_W-1:0] width_mask(input logic [SIZE_W-1:0] sz);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < DATA_W; i++)
         if (i < (BYTE_W << lane_of(sz))) m[i] = 1'b1;
      return m;
   endfunction

   function automatic logic top_of(input logic [DATA_W-1:0] x, input logic [SIZE_W-1:0] sz);
      return x[(BYTE_W << lane_of(sz)) - 1];
   endfunction

   logic past_valid;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_valid <= 1'b0;
      else        past_valid <= 1'b1;
   end

   assert_width_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid |-> ((result_o & ~width_mask($past(size_i))) == '0));

   assert_shl_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && $past(op_i) == OP_SHL_LOG) |-> (c_o == top_of($past(operand_i), $past(size_i))));

   assert_rolc_lsb_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && $past(op_i) == OP_ROLC) |-> (result_o[0] == $past(carry_i)));

   assert_inv_keeps_c_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && $past(op_i) == OP_INV) |-> (c_o == $past(carry_i)));

   assert_zero_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid |-> (z_o == (result_o == '0)));

   assert_neg_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
      past_valid |-> (n_o == top_of(result_o, $past(size_i))));

   assert_spare_pass_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && $past(op_i) > OP_INV) |-> (result_o == ($past(operand_i) & width_mask($past(size_i)))));
endmodule

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb_top;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] operand_i = '0;
   logic          carry_i = 1'b0;
   logic [3:0]    op_i = '0;
   logic [1:0]    size_i = '0;
   logic [DW-1:0] result_o;
   logic          n_o, z_o, v_o, c_o;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   shrot_unit #(.BYTE_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .operand_i(operand_i), .carry_i(carry_i),
      .op_i(op_i), .size_i(size_i), .result_o(result_o),
      .n_o(n_o), .z_o(z_o), .v_o(v_o), .c_o(c_o));

   task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h (op=%0d size=%0d opnd=%0h cin=%0b)",
                  tag, act, exp, op_i, size_i, operand_i, carry_i);
      end
   endtask

   function automatic string op_tag(input int op);
      case (op)
         0, 2: return "R4";
         1: return "R5";
         3: return "R6";
         4: return "R7";
         5: return "R8";
         6: return "R9";
         7: return "R10";
         8: return "R11";
         default: return "R13";
      endcase
   endfunction

   // Arithmetic model of the requirements.
   task automatic model(input int op, input int sz, input longint unsigned x, input bit cin,
                        output longint unsigned r, output bit c);
      int w;
      longint unsigned m, xv, top;
      bit b0, tb;
      w   = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
      m   = (64'd1 << w) - 1;
      top = 64'd1 << (w - 1);
      xv  = x & m;
      b0  = xv[0];
      tb  = (xv / top) % 2 == 1;
      case (op)
         0, 2: begin r = (xv * 2) % (m + 1); c = tb; end
         1:    begin r = xv / 2; c = b0; end
         3:    begin r = xv / 2 + (tb ? top : 0); c = b0; end
         4:    begin r = (xv * 2) % (m + 1) + tb; c = tb; end
         5:    begin r = xv / 2 + (b0 ? top : 0); c = b0; end
         6:    begin r = (xv * 2) % (m + 1) + cin; c = tb; end
         7:    begin r = xv / 2 + (cin ? top : 0); c = b0; end
         8:    begin r = m - xv; c = cin; end
         default: begin r = xv; c = cin; end
      endcase
   endtask

   task automatic run_one(input int op, input int sz, input longint unsigned x, input bit cin);
      longint unsigned er, top;
      bit ec;
      int w;
      op_i = op[3:0]; size_i = sz[1:0]; operand_i = x[DW-1:0]; carry_i = cin;
      model(op, sz, x, cin, er, ec);
      w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
      top = 64'd1 << (w - 1);
      @(negedge clk);
      check({"R3/", op_tag(op), " result"}, longint'(result_o), er);
      check({op_tag(op), " carry"}, longint'(c_o), longint'(ec));
      check("R12 negative", longint'(n_o), ((er / top) % 2));
      check("R12 zero", longint'(z_o), (er == 0) ? 1 : 0);
      check("R12 overflow", longint'(v_o), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      operand_i = 32'hFFFF_FFFF; carry_i = 1'b1; op_i = 4'd8;
      repeat (3) @(negedge clk);
      // R1: held in reset
      check("R1 result in reset", longint'(result_o), 0);
      check("R1 flags in reset", longint'({n_o, z_o, v_o, c_o}), 0);
      rst_n = 1'b1;

      // R2: one-cycle latency; mid-cycle input changes do not show until the edge
      run_one(0, 0, 64'h81, 1'b0);
      operand_i = 32'h0000_0040; op_i = 4'd1;
      #2;
      check("R2 hold between edges", longint'(result_o), 64'h02);
      check("R2 carry hold", longint'(c_o), 1);
      @(negedge clk);
      check("R2 next edge result", longint'(result_o), 64'h20);

      for (int op = 0; op < 16; op++)
         for (int sz = 0; sz < 4; sz++)
            for (int cin = 0; cin < 2; cin++)
               for (int i = 0; i < 256; i++) begin
                  longint unsigned x;
                  int w;
                  w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
                  x = {32'd0, $urandom()};
                  if (i == 0)      x = x & ~((64'd1 << w) - 1);
                  else if (i == 1) x = x | ((64'd1 << w) - 1);
                  else if (i == 2) x = (x & ~((64'd1 << w) - 1)) | (64'd1 << (w - 1));
                  else if (i == 3) x = (x & ~((64'd1 << w) - 1)) | 64'd1;
                  else if (sz == 0) x = (x & ~64'hFF) | longint'(i);
                  x = x & 64'hFFFF_FFFF;
                  run_one(op, sz, x, cin[0]);
               end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule